// File: doc/BRIEF.md
# Converter Sample Timing Generator

This block derives the timing of an analogue-to-digital converter from one fixed input clock. A pre-divider produces a core-clock enable (`core_tick`), a single-cycle pulse once every 4 to 128 input clocks. A period counter then groups these ticks into sample periods of (time unit + 1) × 6 core ticks. At the end of each period it raises a single-cycle start strobe (`sample_strobe`) for the channel sequencer. The sample rate is therefore the input clock / pre-divide / ((unit + 1) × 6).

Two registered words program the block. The timer word carries a 3-bit pre-divider code and a time-unit field. The global word carries enable, power-down and clock-down controls. Gating is modelled as a clock enable: while the block is gated both counters hold their state and no pulse leaves the block. A new timer word is taken only while all channels are idle. Taking it restarts both counters, so the first strobe comes a full period after the write.

Top module: `sts_sample_timer`

## Requirements
- R1: After reset the block is gated: the global word resets to enable=0, power-down=1, clock-down=1, the timer word to code 0 and unit 0, and neither `core_tick` nor `sample_strobe` pulses until the block is enabled.
- R2: The pre-divider code is taken from `tmr_wdata[31:29]`. Codes 0, 1, 2, 3, 4 and 5 give one `core_tick` every 4, 8, 16, 32, 64 and 128 input clocks respectively.
- R3: Codes 6 and 7 divide by 128, the same as code 5.
- R4: The time unit is `tmr_wdata[UNIT_W-1:0]`. Consecutive strobes are (unit + 1) × 6 core ticks apart, and exactly that many ticks fall in each strobe-to-strobe interval.
- R5: `sample_strobe` is a one-cycle pulse that is high only in a cycle where `core_tick` is also high.
- R6: The global word bit 0 is enable, bit 1 is power-down and bit 31 is clock-down. The block runs only when enable is 1 and both down bits are 0. Otherwise `core_tick` and `sample_strobe` stay low.
- R7: While gated, both counters hold their state. A stall of S clock edges delays the next strobe by exactly S cycles.
- R8: A timer write made while any bit of `chan_en` is 1 is ignored: the code, the unit and the running counters are unchanged.
- R9: An accepted timer write clears both counters at its clock edge. With the block running, the first strobe follows that edge by D × (unit + 1) × 6 − 1 further edges, where D is the divide. A restart wins over a strobe due in the same cycle.
- R10: A global write takes effect at its own clock edge. That edge still advances the counters under the old setting, and the new gating applies from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | NCH | Channel enables from the sequencer; any set bit blocks timer writes |
| tmr_wr | input | 1 | Timer word write strobe |
| tmr_wdata | input | 32 | Timer word: code in [31:29], time unit in [UNIT_W-1:0] |
| gcfg_wr | input | 1 | Global word write strobe |
| gcfg_wdata | input | 32 | Global word: clock-down [31], power-down [1], enable [0] |
| core_tick | output | 1 | Core-clock enable pulse |
| sample_strobe | output | 1 | Sample-start pulse, one input clock wide |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an accepted timer write and the strobe that would end the current period. The bench provokes this by driving the write in the very cycle where it sees the strobe high. It then judges that the next strobe comes a full new period later, not at the old spacing. The second pair is a gating write and counter progress on the same edge: the bench stalls the block mid-period and requires the strobe to move by exactly the stalled edge count, which separates "the write edge still counts" from "the write edge is already gated".

// File: rtl/sts_pkg.sv
package sts_pkg;

  localparam int TMR_CODE_HI = 31;
  localparam int TMR_CODE_LO = 29;
  localparam int CODE_W      = TMR_CODE_HI - TMR_CODE_LO + 1;
  localparam int GCFG_EN     = 0;
  localparam int GCFG_PWRDN  = 1;
  localparam int GCFG_CLKDN  = 31;
  localparam int PRE_W       = 7;  // holds a divide of up to 128
  localparam int MAX_SHIFT   = 5;  // 4 << 5 = 128
  localparam int SLOTS_PER_UNIT = 6;

  typedef struct packed {
    logic clk_down;
    logic pwr_down;
    logic enable;
  } gate_cfg_t;

  localparam gate_cfg_t GATE_RESET = '{clk_down: 1'b1, pwr_down: 1'b1, enable: 1'b0};

  // divide minus one for a pre-divider code; codes above 5 saturate at 128
  function automatic logic [PRE_W-1:0] pre_limit(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] sh;
    logic [PRE_W:0]    dv;
    sh = (code > CODE_W'(MAX_SHIFT)) ? CODE_W'(MAX_SHIFT) : code;
    dv = (PRE_W+1)'(4) << sh;
    return PRE_W'(dv - (PRE_W+1)'(1));
  endfunction

endpackage

// File: rtl/sts_cfg_regs.sv
module sts_cfg_regs
  import sts_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int UNIT_W = 8,
  parameter int NCH    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_en,
  input  logic              tmr_wr,
  input  logic [DATA_W-1:0] tmr_wdata,
  input  logic              gcfg_wr,
  input  logic [DATA_W-1:0] gcfg_wdata,
  output logic [CODE_W-1:0] pdiv_code,
  output logic [UNIT_W-1:0] unit,
  output logic              run,
  output logic              restart
);

  gate_cfg_t         gate_q, gate_d;
  logic [CODE_W-1:0] code_d;
  logic [UNIT_W-1:0] unit_d;
  logic              tmr_take;

  logic unused_tmr_bits;
  logic unused_gcfg_bits;
  assign unused_tmr_bits  = ^tmr_wdata[TMR_CODE_LO-1:UNIT_W];
  assign unused_gcfg_bits = ^gcfg_wdata[GCFG_CLKDN-1:GCFG_PWRDN+1];

  // timer word is accepted only while every channel is idle
  assign tmr_take = tmr_wr & ~(|chan_en);

  always_comb begin
    code_d = pdiv_code;
    unit_d = unit;
    if (tmr_take) begin
      code_d = tmr_wdata[TMR_CODE_HI:TMR_CODE_LO];
      unit_d = tmr_wdata[UNIT_W-1:0];
    end
  end

  always_comb begin
    gate_d = gate_q;
    if (gcfg_wr) begin
      gate_d.clk_down = gcfg_wdata[GCFG_CLKDN];
      gate_d.pwr_down = gcfg_wdata[GCFG_PWRDN];
      gate_d.enable   = gcfg_wdata[GCFG_EN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdiv_code <= '0;
      unit      <= '0;
    end else if (tmr_take) begin
      pdiv_code <= code_d;
      unit      <= unit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= GATE_RESET;
    end else if (gcfg_wr) begin
      gate_q <= gate_d;
    end
  end

  assign run     = gate_q.enable & ~gate_q.pwr_down & ~gate_q.clk_down;
  assign restart = tmr_take;

endmodule

// File: rtl/sts_prediv.sv
module sts_prediv
  import sts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] pdiv_code,
  output logic              tick
);

  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] limit;
  logic             cnt_en;

  assign limit  = pre_limit(pdiv_code);
  assign tick   = run & (cnt_q == limit);
  assign cnt_en = run | restart;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sts_period.sv
module sts_period
  import sts_pkg::*;
#(
  parameter int UNIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              restart,
  input  logic [UNIT_W-1:0] unit,
  output logic              strobe
);

  localparam int CNT_W = UNIT_W + 3;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;
  logic             cnt_en;

  assign last   = (CNT_W'(unit) + CNT_W'(1)) * CNT_W'(SLOTS_PER_UNIT) - CNT_W'(1);
  assign strobe = tick & (cnt_q == last);
  assign cnt_en = tick | restart;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (strobe) cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sts_sample_timer.sv
module sts_sample_timer
  import sts_pkg::*;
#(
  parameter int UNIT_W = 8,
  parameter int NCH    = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_en,
  input  logic           tmr_wr,
  input  logic [31:0]    tmr_wdata,
  input  logic           gcfg_wr,
  input  logic [31:0]    gcfg_wdata,
  output logic           core_tick,
  output logic           sample_strobe
);

  logic [CODE_W-1:0] pdiv_code;
  logic [UNIT_W-1:0] unit;
  logic              run;
  logic              restart;

  sts_cfg_regs #(.DATA_W(32), .UNIT_W(UNIT_W), .NCH(NCH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .tmr_wr     (tmr_wr),
    .tmr_wdata  (tmr_wdata),
    .gcfg_wr    (gcfg_wr),
    .gcfg_wdata (gcfg_wdata),
    .pdiv_code  (pdiv_code),
    .unit       (unit),
    .run        (run),
    .restart    (restart)
  );

  sts_prediv u_prediv (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .restart   (restart),
    .pdiv_code (pdiv_code),
    .tick      (core_tick)
  );

  sts_period #(.UNIT_W(UNIT_W)) u_period (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (core_tick),
    .restart (restart),
    .unit    (unit),
    .strobe  (sample_strobe)
  );

endmodule

// File: rtl/sts_sample_timer_chk.sv
module sts_sample_timer_chk #(
  parameter int UNIT_W = 8,
  parameter int NCH    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    chan_en,
  input logic              tmr_wr,
  input logic [2:0]        wr_code,
  input logic              run,
  input logic              restart,
  input logic [2:0]        pdiv_code,
  input logic [UNIT_W-1:0] unit,
  input logic              core_tick,
  input logic              sample_strobe
);

  AST_STROBE_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> core_tick);  // R5

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> !sample_strobe);  // R5

  AST_GATED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!core_tick && !sample_strobe));  // R6

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !core_tick);  // R9

  AST_CODE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pdiv_code == $past(wr_code)));  // R2

  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_wr && (|chan_en)) |=> ($stable(pdiv_code) && $stable(unit)));  // R8

endmodule

bind sts_sample_timer sts_sample_timer_chk #(.UNIT_W(UNIT_W), .NCH(NCH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .chan_en       (chan_en),
  .tmr_wr        (tmr_wr),
  .wr_code       (tmr_wdata[31:29]),
  .run           (run),
  .restart       (restart),
  .pdiv_code     (pdiv_code),
  .unit          (unit),
  .core_tick     (core_tick),
  .sample_strobe (sample_strobe)
);

// File: tb/sts_sample_timer_tb.sv
`timescale 1ns/1ps
module sts_sample_timer_tb;

  localparam int NCH = 4;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] chan_en;
  logic           tmr_wr;
  logic [31:0]    tmr_wdata;
  logic           gcfg_wr;
  logic [31:0]    gcfg_wdata;
  logic           core_tick;
  logic           sample_strobe;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  sts_sample_timer #(.UNIT_W(8), .NCH(NCH)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .chan_en       (chan_en),
    .tmr_wr        (tmr_wr),
    .tmr_wdata     (tmr_wdata),
    .gcfg_wr       (gcfg_wr),
    .gcfg_wdata    (gcfg_wdata),
    .core_tick     (core_tick),
    .sample_strobe (sample_strobe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_div(input int code);
    int c;
    c = (code > 5) ? 5 : code;
    return 4 << c;
  endfunction

  function automatic int exp_len(input int u);
    return (u + 1) * 6;
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_tmr(input int code, input int u);
    tmr_wr    = 1'b1;
    tmr_wdata = {3'(code), 29'(u)};
    step();
    tmr_wr    = 1'b0;
  endtask

  task automatic wr_gcfg(input logic [31:0] w);
    gcfg_wr    = 1'b1;
    gcfg_wdata = w;
    step();
    gcfg_wr    = 1'b0;
  endtask

  // steps until strobe is seen at a sample point; counts ticks seen
  task automatic run_until_strobe(input int maxc, output int n, output int nt);
    n  = 0;
    nt = 0;
    do begin
      step();
      n++;
      if (core_tick) nt++;
    end while (!sample_strobe && n < maxc);
  endtask

  task automatic count_pulses(input int cyc, output int nt, output int ns);
    nt = 0;
    ns = 0;
    for (int i = 0; i < cyc; i++) begin
      step();
      if (core_tick) nt++;
      if (sample_strobe) ns++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int n, nt, ns, code, u, stall;
    void'($urandom(32'd20240611));
    rst_n      = 1'b0;
    chan_en    = '0;
    tmr_wr     = 1'b0;
    tmr_wdata  = '0;
    gcfg_wr    = 1'b0;
    gcfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: gated after reset
    count_pulses(200, nt, ns);
    check_eq("R1 ticks after reset", nt, 0);
    check_eq("R1 strobes after reset", ns, 0);

    // R6: enable alone starts the block; R9 first strobe after restart
    wr_gcfg(32'h0000_0001);
    wr_tmr(0, 0);
    run_until_strobe(20000, n, nt);
    check_eq("R9 first strobe edge count", n, exp_div(0) * exp_len(0) - 1);
    run_until_strobe(20000, n, nt);
    check_eq("R4 period cycles", n, exp_div(0) * exp_len(0));
    check_eq("R4 ticks per period", nt, exp_len(0));
    step();
    check_eq("R5 strobe one cycle wide", int'(sample_strobe), 0);

    // R2 R3 R4: random codes and units
    for (int k = 0; k < 6; k++) begin
      code = int'($urandom % 8);
      u    = int'($urandom % 6);
      wr_tmr(code, u);
      run_until_strobe(20000, n, nt);
      check_eq(code > 5 ? "R3 first strobe" : "R2 first strobe", n, exp_div(code) * exp_len(u) - 1);
      run_until_strobe(20000, n, nt);
      check_eq("R4 random period", n, exp_div(code) * exp_len(u));
      check_eq("R4 random ticks", nt, exp_len(u));
    end

    // R3 directed: codes 6 and 7 equal 128
    wr_tmr(6, 0);
    run_until_strobe(20000, n, nt);
    check_eq("R3 code6 first strobe", n, 128 * 6 - 1);
    wr_tmr(7, 0);
    run_until_strobe(20000, n, nt);
    check_eq("R3 code7 first strobe", n, 128 * 6 - 1);
    wr_tmr(5, 0);
    run_until_strobe(20000, n, nt);
    check_eq("R2 code5 first strobe", n, 128 * 6 - 1);

    // R6: each down bit or a cleared enable stops everything
    wr_tmr(0, 0);
    wr_gcfg(32'h8000_0001);
    count_pulses(100, nt, ns);
    check_eq("R6 clock-down ticks", nt + ns, 0);
    wr_gcfg(32'h0000_0003);
    count_pulses(100, nt, ns);
    check_eq("R6 power-down ticks", nt + ns, 0);
    wr_gcfg(32'h0000_0000);
    count_pulses(100, nt, ns);
    check_eq("R6 enable-clear ticks", nt + ns, 0);

    // R7 R10: stall mid-period, strobe moves by the stalled edges
    wr_gcfg(32'h0000_0001);
    stall = 37;
    wr_tmr(0, 1);
    n = 0;
    repeat (10) begin step(); n++; end
    wr_gcfg(32'h0000_0002); n++;   // this edge still counts (R10)
    count_pulses(stall, nt, ns); n += stall;
    check_eq("R7 silent during stall", nt + ns, 0);
    wr_gcfg(32'h0000_0001); n++;   // gated edge
    run_until_strobe(20000, nt, ns);
    check_eq("R7 R10 delayed strobe", n + nt, exp_div(0) * exp_len(1) - 1 + stall + 1);

    // R8: write with a channel enabled is ignored
    chan_en = 4'b0100;
    wr_tmr(5, 7);
    run_until_strobe(20000, n, nt);
    run_until_strobe(20000, n, nt);
    check_eq("R8 period unchanged", n, exp_div(0) * exp_len(1));
    chan_en = '0;

    // R9: restart coincident with a strobe
    check_eq("R9 at strobe", int'(sample_strobe), 1);
    wr_tmr(1, 2);
    run_until_strobe(20000, n, nt);
    check_eq("R9 restart wins over strobe", n, exp_div(1) * exp_len(2) - 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule